// File: doc/BRIEF.md
# CAN Message Object Acceptance Filter

This block decides which message object, if any, accepts a frame that has just arrived from the bus. A request carries the frame's identifier, its IDE bit (standard or extended) and its RTR bit (data or remote). The block then walks an external table of message objects one entry per cycle. It reads each entry through a table read port with zero latency, and it stops at the first entry that accepts the frame. It reports done, a hit flag and the object index. When a remote frame lands on an object that is enabled to answer remote frames, it also pulses a transmit-request trigger.

Each object carries a valid bit, a use-mask bit, a 29-bit identifier, an extended flag, a direction flag, a 29-bit identifier mask, a mask-extended flag, a mask-direction flag and a remote-answer enable. A standard identifier sits in the upper 11 bits of the 29-bit identifier field.

The request side is valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low for the whole scan. A sender that sees `req_ready` low must hold its request, unchanged, until it is taken. The result side is plain status: a one-cycle `res_done` pulse, with `res_hit` and `res_idx` held until the next pulse.

Top module: `can_msg_filter`

## Requirements
- R1: An object whose valid bit is 0 never accepts a frame. The scan moves past it, even when every other field matches.
- R2: With use-mask 0, an extended frame (IDE 1) is accepted only when all 29 identifier bits are equal, IDE equals the extended flag, and the direction matches.
- R3: With use-mask 1, only identifier bits whose mask bit is 1 must be equal. Bits whose mask bit is 0 cannot block acceptance.
- R4: For a standard frame (IDE 0), bits 10..0 of `req_id` are compared against object identifier bits 28..18. Object identifier bits 17..0 and `req_id` bits 28..11 have no effect.
- R5: IDE must equal the object's extended flag when use-mask is 0 or mask-extended is 1. With use-mask 1 and mask-extended 0, IDE is ignored.
- R6: The required direction flag equals RTR: a data frame (RTR 0) needs direction 0 (receive object), and a remote frame (RTR 1) needs direction 1 (transmit object). The check applies unless use-mask is 1 and mask-direction is 0.
- R7: When several objects accept a frame, `res_idx` is the lowest accepting index.
- R8: A hit at object n raises `res_done` for one cycle, n+1 clock edges after the accepting edge. A miss raises it 32 edges after the accepting edge, with `res_hit` 0 and `res_idx` 0. `res_hit` and `res_idx` hold between pulses.
- R9: `req_ready` drops on the edge that takes a request, stays low while scanning, and is high in the `res_done` cycle. A request held while not ready is taken after the scan ends, and its own result follows.
- R10: `res_txrqst_set` pulses together with `res_done` only when the hit is for a remote frame (RTR 1) and that object's remote-answer enable is 1.
- R11: While reset is active, `req_ready` is 1 and `res_done`, `res_hit`, `res_idx` and `res_txrqst_set` are 0.
- R12: From the edge that takes a request, `tbl_addr` is 0 and then rises by one per cycle until the scan ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Frame request offered |
| req_ready | output | 1 | Filter idle, request can be taken |
| req_id | input | 29 | Frame identifier; standard frames use bits 10..0 |
| req_ide | input | 1 | 1 = extended frame |
| req_rtr | input | 1 | 1 = remote frame |
| tbl_addr | output | 5 | Object index being read |
| tbl_valid | input | 1 | Object valid |
| tbl_umask | input | 1 | Object uses its mask |
| tbl_id | input | 29 | Object identifier |
| tbl_xtd | input | 1 | Object extended flag |
| tbl_dir | input | 1 | Object direction, 1 = transmit |
| tbl_msk | input | 29 | Object identifier mask |
| tbl_mxtd | input | 1 | Mask applies to IDE |
| tbl_mdir | input | 1 | Mask applies to direction |
| tbl_rmten | input | 1 | Object answers remote frames |
| res_done | output | 1 | Scan finished (one-cycle pulse) |
| res_hit | output | 1 | An object accepted the frame |
| res_idx | output | 5 | Accepting object index |
| res_txrqst_set | output | 1 | Set transmit request of accepting object |

## Verification
Two things can land in one cycle. First, the end of a scan with a hit can coincide with the transmit-request trigger. Remote frames are aimed at transmit objects with remote-answer both on and off, and the trigger is judged by whether it pulses exactly with `res_done` for the right index. Second, a new request held during a busy scan is taken in the very cycle the previous result is reported. The bench checks that the first result stays intact and that the second frame is then scanned on its own.

// File: rtl/can_filt_pkg.sv
`timescale 1ns/1ps
package can_filt_pkg;
  localparam int ID_W  = 29;
  localparam int STD_W = 11;
  localparam int LOW_W = ID_W - STD_W;

  typedef struct packed {
    logic [ID_W-1:0] id;
    logic            ide;
    logic            rtr;
  } frame_t;

  typedef struct packed {
    logic            valid;
    logic            umask;
    logic [ID_W-1:0] id;
    logic            xtd;
    logic            dir;
    logic [ID_W-1:0] msk;
    logic            mxtd;
    logic            mdir;
  } obj_t;
endpackage

// File: rtl/can_id_align.sv
`timescale 1ns/1ps
module can_id_align
  import can_filt_pkg::*;
(
  input  frame_t          raw,
  output frame_t          algn,
  output logic [ID_W-1:0] lane_en
);
  // Standard identifiers are moved to the top of the field; the low lanes are then idle.
  always_comb begin
    algn = raw;
    if (!raw.ide) algn.id = {raw.id[STD_W-1:0], {LOW_W{1'b0}}};
  end

  for (genvar b = 0; b < ID_W; b++) begin : g_lane
    if (b >= LOW_W) begin : g_top
      assign lane_en[b] = 1'b1;
    end else begin : g_low
      assign lane_en[b] = raw.ide;
    end
  end
endmodule

// File: rtl/can_obj_match.sv
`timescale 1ns/1ps
module can_obj_match
  import can_filt_pkg::*;
(
  input  frame_t          frm,
  input  logic [ID_W-1:0] lane_en,
  input  obj_t            obj,
  output logic            hit
);
  logic [ID_W-1:0] bit_ok;
  logic            ide_ok;
  logic            dir_ok;

  for (genvar b = 0; b < ID_W; b++) begin : g_bit
    assign bit_ok[b] = !lane_en[b] || (obj.umask && !obj.msk[b]) ||
                       (frm.id[b] == obj.id[b]);
  end

  assign ide_ok = (obj.umask && !obj.mxtd) || (frm.ide == obj.xtd);
  assign dir_ok = (obj.umask && !obj.mdir) || (frm.rtr == obj.dir);
  assign hit    = obj.valid && (&bit_ok) && ide_ok && dir_ok;
endmodule

// File: rtl/can_scan_ctrl.sv
`timescale 1ns/1ps
module can_scan_ctrl #(
  parameter int NUM_OBJ = 32,
  localparam int IDX_W  = $clog2(NUM_OBJ)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             obj_hit,
  input  logic             obj_rmten,
  input  logic             frm_rtr,
  output logic             busy,
  output logic [IDX_W-1:0] idx,
  output logic             done,
  output logic             hit_q,
  output logic [IDX_W-1:0] idx_q,
  output logic             txr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_OBJ - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      idx   <= '0;
      done  <= 1'b0;
      hit_q <= 1'b0;
      idx_q <= '0;
      txr   <= 1'b0;
    end else begin
      done <= 1'b0;
      txr  <= 1'b0;
      if (busy) begin
        if (obj_hit) begin
          busy  <= 1'b0;
          done  <= 1'b1;
          hit_q <= 1'b1;
          idx_q <= idx;
          txr   <= frm_rtr && obj_rmten;
        end else if (idx == LAST) begin
          busy  <= 1'b0;
          done  <= 1'b1;
          hit_q <= 1'b0;
          idx_q <= '0;
        end else begin
          idx <= idx + 1'b1;
        end
      end else if (fire) begin
        busy <= 1'b1;
        idx  <= '0;
      end
    end
  end
endmodule

// File: rtl/can_msg_filter.sv
`timescale 1ns/1ps
module can_msg_filter
  import can_filt_pkg::*;
#(
  parameter int NUM_OBJ = 32,
  localparam int IDX_W  = $clog2(NUM_OBJ)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [ID_W-1:0]  req_id,
  input  logic             req_ide,
  input  logic             req_rtr,
  output logic [IDX_W-1:0] tbl_addr,
  input  logic             tbl_valid,
  input  logic             tbl_umask,
  input  logic [ID_W-1:0]  tbl_id,
  input  logic             tbl_xtd,
  input  logic             tbl_dir,
  input  logic [ID_W-1:0]  tbl_msk,
  input  logic             tbl_mxtd,
  input  logic             tbl_mdir,
  input  logic             tbl_rmten,
  output logic             res_done,
  output logic             res_hit,
  output logic [IDX_W-1:0] res_idx,
  output logic             res_txrqst_set
);
  frame_t          frm_in, frm_q, frm_al;
  logic [ID_W-1:0] lane_en;
  obj_t            obj;
  logic            busy, fire, obj_hit;

  assign frm_in    = '{id: req_id, ide: req_ide, rtr: req_rtr};
  assign req_ready = !busy;
  assign fire      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)    frm_q <= '0;
    else if (fire) frm_q <= frm_in;
  end

  assign obj = '{valid: tbl_valid, umask: tbl_umask, id: tbl_id, xtd: tbl_xtd,
                 dir: tbl_dir, msk: tbl_msk, mxtd: tbl_mxtd, mdir: tbl_mdir};

  can_id_align u_align (
    .raw     (frm_q),
    .algn    (frm_al),
    .lane_en (lane_en)
  );

  can_obj_match u_match (
    .frm     (frm_al),
    .lane_en (lane_en),
    .obj     (obj),
    .hit     (obj_hit)
  );

  can_scan_ctrl #(.NUM_OBJ(NUM_OBJ)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (fire),
    .obj_hit   (obj_hit),
    .obj_rmten (tbl_rmten),
    .frm_rtr   (frm_q.rtr),
    .busy      (busy),
    .idx       (tbl_addr),
    .done      (res_done),
    .hit_q     (res_hit),
    .idx_q     (res_idx),
    .txr       (res_txrqst_set)
  );
endmodule

// File: rtl/can_filt_chk.sv
`timescale 1ns/1ps
module can_filt_chk #(
  parameter int NUM_OBJ = 32,
  localparam int IDX_W  = $clog2(NUM_OBJ)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [IDX_W-1:0] tbl_addr,
  input logic             tbl_valid,
  input logic             tbl_rmten,
  input logic             res_done,
  input logic             res_hit,
  input logic [IDX_W-1:0] res_idx,
  input logic             res_txrqst_set
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_OBJ - 1);

  p_invalid_skip_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !tbl_valid) |=> !(res_done && res_hit));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |=> !res_done);

  p_miss_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_done && !res_hit) |-> ($past(tbl_addr) == LAST && res_idx == '0));

  p_hit_index_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_done && res_hit) |-> res_idx == $past(tbl_addr));

  p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !res_done |=> (res_done || ($stable(res_hit) && $stable(res_idx))));

  p_ready_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_ready_at_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |-> req_ready);

  p_tx_with_hit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    res_txrqst_set |-> (res_done && res_hit && $past(tbl_rmten)));

  p_addr_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> (res_done || tbl_addr == $past(tbl_addr) + IDX_W'(1)));
endmodule

bind can_msg_filter can_filt_chk #(.NUM_OBJ(NUM_OBJ)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .tbl_addr       (tbl_addr),
  .tbl_valid      (tbl_valid),
  .tbl_rmten      (tbl_rmten),
  .res_done       (res_done),
  .res_hit        (res_hit),
  .res_idx        (res_idx),
  .res_txrqst_set (res_txrqst_set)
);

// File: tb/test_can_msg_filter.sv
`timescale 1ns/1ps
module test_can_msg_filter;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_ide, req_rtr;
  logic [28:0] req_id;
  logic [4:0]  tbl_addr, res_idx;
  logic        tbl_valid, tbl_umask, tbl_xtd, tbl_dir, tbl_mxtd, tbl_mdir, tbl_rmten;
  logic [28:0] tbl_id, tbl_msk;
  logic        res_done, res_hit, res_txrqst_set;

  int checks = 0;
  int errors = 0;

  logic        t_valid [N];
  logic        t_umask [N];
  logic        t_xtd   [N];
  logic        t_dir   [N];
  logic        t_mxtd  [N];
  logic        t_mdir  [N];
  logic        t_rmten [N];
  logic [28:0] t_id    [N];
  logic [28:0] t_msk   [N];

  always #2 clk = ~clk;

  always_comb begin
    tbl_valid = t_valid[tbl_addr];
    tbl_umask = t_umask[tbl_addr];
    tbl_id    = t_id[tbl_addr];
    tbl_xtd   = t_xtd[tbl_addr];
    tbl_dir   = t_dir[tbl_addr];
    tbl_msk   = t_msk[tbl_addr];
    tbl_mxtd  = t_mxtd[tbl_addr];
    tbl_mdir  = t_mdir[tbl_addr];
    tbl_rmten = t_rmten[tbl_addr];
  end

  can_msg_filter i_can_msg_filter (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_id(req_id), .req_ide(req_ide), .req_rtr(req_rtr), .tbl_addr(tbl_addr),
    .tbl_valid(tbl_valid), .tbl_umask(tbl_umask), .tbl_id(tbl_id), .tbl_xtd(tbl_xtd),
    .tbl_dir(tbl_dir), .tbl_msk(tbl_msk), .tbl_mxtd(tbl_mxtd), .tbl_mdir(tbl_mdir),
    .tbl_rmten(tbl_rmten), .res_done(res_done), .res_hit(res_hit), .res_idx(res_idx),
    .res_txrqst_set(res_txrqst_set)
  );

  // {req tag, id, ide, rtr, exp hit, exp idx, exp txrqst}
  localparam int NV = 17;
  localparam logic [41:0] VEC [NV] = '{
    {4'd1,  29'h1234567, 1'b1, 1'b0, 1'b1, 5'd3,  1'b0}, // R1 invalid obj 1 skipped, R2 exact
    {4'd2,  29'h1234566, 1'b1, 1'b0, 1'b0, 5'd0,  1'b0}, // R2 one bit off
    {4'd6,  29'h1234567, 1'b1, 1'b1, 1'b0, 5'd0,  1'b0}, // R6 remote vs receive obj
    {4'd5,  29'h1234567, 1'b0, 1'b0, 1'b0, 5'd0,  1'b0}, // R5 IDE mismatch, exact
    {4'd4,  29'h0000123, 1'b0, 1'b0, 1'b1, 5'd5,  1'b0}, // R4 standard id
    {4'd4,  29'h1ABCD123, 1'b0, 1'b0, 1'b1, 5'd5, 1'b0}, // R4 upper frame bits ignored
    {4'd3,  29'h0ABCDE5A, 1'b1, 1'b0, 1'b1, 5'd7,  1'b0}, // R3 masked low byte
    {4'd3,  29'h0ABCDFFF, 1'b1, 1'b0, 1'b0, 5'd0,  1'b0}, // R3 masked-in bit differs
    {4'd6,  29'h0ABCDE5A, 1'b1, 1'b1, 1'b0, 5'd0,  1'b0}, // R6 mask-direction on
    {4'd5,  29'h0ABCDE5A, 1'b0, 1'b0, 1'b0, 5'd0,  1'b0}, // R5 mask-extended on
    {4'd10, 29'h00002AA, 1'b0, 1'b1, 1'b1, 5'd9,  1'b1}, // R10 remote answer, R4 obj low bits
    {4'd6,  29'h00002AA, 1'b0, 1'b0, 1'b0, 5'd0,  1'b0}, // R6 data vs transmit obj
    {4'd6,  29'h0000155, 1'b0, 1'b1, 1'b1, 5'd11, 1'b0}, // R6 direction masked, R10 no enable
    {4'd5,  29'h05552345, 1'b1, 1'b0, 1'b1, 5'd11, 1'b0}, // R5 IDE masked out
    {4'd7,  29'h0000077, 1'b1, 1'b0, 1'b1, 5'd13, 1'b0}, // R7 13 and 14 both accept
    {4'd8,  29'h1FFFFFFF, 1'b1, 1'b0, 1'b1, 5'd31, 1'b0}, // R8 last object
    {4'd8,  29'h1FFFFFFE, 1'b1, 1'b0, 1'b0, 5'd0,  1'b0}  // R8 full miss
  };

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_tbl();
    for (int i = 0; i < N; i++) begin
      t_valid[i] = 0; t_umask[i] = 0; t_xtd[i] = 0; t_dir[i] = 0; t_mxtd[i] = 0;
      t_mdir[i] = 0; t_rmten[i] = 0; t_id[i] = '0; t_msk[i] = '0;
    end
  endtask

  task automatic set_obj(input int i, input logic v, input logic um, input logic [28:0] id,
                         input logic x, input logic d, input logic [28:0] m,
                         input logic mx, input logic md, input logic re);
    t_valid[i] = v; t_umask[i] = um; t_id[i] = id; t_xtd[i] = x; t_dir[i] = d;
    t_msk[i] = m; t_mxtd[i] = mx; t_mdir[i] = md; t_rmten[i] = re;
  endtask

  task automatic base_tbl();
    clear_tbl();
    set_obj(1,  0, 0, 29'h1234567, 1, 0, '0, 0, 0, 0);
    set_obj(3,  1, 0, 29'h1234567, 1, 0, '0, 0, 0, 0);
    set_obj(5,  1, 0, {11'h123, 18'h0}, 0, 0, '0, 0, 0, 0);
    set_obj(7,  1, 1, 29'h0ABCDE00, 1, 0, 29'h1FFFFF00, 1, 1, 0);
    set_obj(9,  1, 0, {11'h2AA, 18'h3FFFF}, 0, 1, '0, 0, 0, 1);
    set_obj(11, 1, 1, {11'h155, 18'h0}, 0, 0, 29'h1FFC0000, 0, 0, 0);
    set_obj(13, 1, 0, 29'h0000077, 1, 0, '0, 0, 0, 0);
    set_obj(14, 1, 0, 29'h0000077, 1, 0, '0, 0, 0, 0);
    set_obj(31, 1, 0, 29'h1FFFFFFF, 1, 0, '0, 0, 0, 0);
  endtask

  // Offers one frame, waits for its result; checks R9 and R12 along the way.
  task automatic run_frame(input logic [28:0] id, input logic ide, input logic rtr,
                           output logic hit, output logic [4:0] idx, output logic tx,
                           output int lat);
    bit addr_ok = 1;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_id = id; req_ide = ide; req_rtr = rtr;
    @(negedge clk);
    req_valid = 0;
    check("R9", "ready after take", 32'(req_ready), 0);
    check("R12", "first address", 32'(tbl_addr), 0);
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      if (!res_done && tbl_addr !== 5'(lat)) addr_ok = 0;
    end while (!res_done && lat < 40);
    check("R12", "address walk", 32'(addr_ok), 1);
    hit = res_hit; idx = res_idx; tx = res_txrqst_set;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic       h, t;
    logic [4:0] ix;
    int         lat;
    rst_n = 0; req_valid = 0; req_id = '0; req_ide = 0; req_rtr = 0;
    base_tbl();
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11", "ready", 32'(req_ready), 1);
    check("R11", "done", 32'(res_done), 0);
    check("R11", "hit", 32'(res_hit), 0);
    check("R11", "idx", 32'(res_idx), 0);
    check("R11", "txrqst", 32'(res_txrqst_set), 0);
    rst_n = 1;

    for (int v = 0; v < NV; v++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[v][41:38], v);
      run_frame(VEC[v][37:9], VEC[v][8], VEC[v][7], h, ix, t, lat);
      check(tag, "hit", 32'(h), 32'(VEC[v][6]));
      check(tag, "idx", 32'(ix), 32'(VEC[v][5:1]));
      check(tag, "txrqst", 32'(t), 32'(VEC[v][0]));
      check("R8", "latency", 32'(lat), VEC[v][6] ? 32'(VEC[v][5:1]) + 1 : 32);
    end

    // R7: accept-all object 20 vs lower exact object 3
    set_obj(20, 1, 1, 29'h0, 0, 0, 29'h0, 0, 0, 1);
    run_frame(29'h1FFFFFFE, 1, 1, h, ix, t, lat);
    check("R7", "accept-all hit", 32'(h), 1);
    check("R7", "accept-all idx", 32'(ix), 20);
    check("R10", "accept-all txrqst", 32'(t), 1);
    run_frame(29'h1234567, 1, 0, h, ix, t, lat);
    check("R7", "lower wins idx", 32'(ix), 3);
    check("R10", "data frame no txrqst", 32'(t), 0);

    // R1: nothing valid
    for (int i = 0; i < N; i++) t_valid[i] = 0;
    run_frame(29'h1234567, 1, 0, h, ix, t, lat);
    check("R1", "all invalid hit", 32'(h), 0);
    check("R1", "all invalid latency", 32'(lat), 32);

    // R9 and R8: a request held during a busy scan
    base_tbl();
    @(negedge clk);
    req_valid = 1; req_id = 29'h1FFFFFFF; req_ide = 1; req_rtr = 0;
    @(negedge clk);
    req_id = 29'h0000123; req_ide = 0;
    lat = 0;
    while (!res_done && lat < 40) begin
      @(negedge clk);
      lat++;
      if (!res_done && req_ready) check("R9", "ready while busy", 1, 0);
    end
    check("R9", "first result idx", 32'(res_idx), 31);
    check("R9", "ready in done cycle", 32'(req_ready), 1);
    @(negedge clk);
    req_valid = 0;
    check("R9", "second taken", 32'(req_ready), 0);
    check("R8", "hold hit", 32'(res_hit), 1);
    check("R8", "hold idx", 32'(res_idx), 31);
    lat = 0;
    while (!res_done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    check("R9", "second result idx", 32'(res_idx), 5);
    check("R8", "second latency", 32'(lat), 6);
    @(negedge clk);
    check("R8", "done is a pulse", 32'(res_done), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule